// File: doc/BRIEF.md
# Symmetric Direct-Form FIR with Merged Partial-Product Accumulation

This block is a linear-phase FIR filter of even order built in direct form. A register chain keeps the last ORDER accepted samples. For each valid input, the filter folds each mirrored pair of taps into a single sum, weights every folded sum by its fixed coefficient, and forms the whole weighted total in one bit matrix. That matrix is reduced by carry-save adders to two rows, and one carry-propagate adder resolves them. The result is rounded, clipped to the sample range and registered.

Coefficients are fixed when the design is built. Each one is recoded at elaboration into signed digits, either canonical signed digit or radix-4 Booth, whichever has fewer nonzero digits. Every nonzero digit becomes one row of the matrix. An optional truncation setting drops the lowest matrix columns and adds a fixed compensation term, which trades one LSB of accuracy for a smaller reduction tree. The filter takes one sample per clock and has one cycle of latency.

Top module: `symfir_merged`

## Requirements
- R1: While rst_n is low and after it rises, out_valid is 0, out_sample is 0 and every stored past sample is 0, so the first output after reset depends only on samples accepted since then.
- R2: out_valid is 1 in the cycle after each cycle with in_valid high, and 0 after each cycle with in_valid low.
- R3: With TRUNC_COLS = 0, the output for accepted sample x(n) equals clip(floor((S + 2^(CF-1)) / 2^CF)). Here S = sum over i < H of a_i*(x(n-i) + x(n-ORDER+i)), plus a_H*x(n-H), with H = ORDER/2. Coefficient a_u is the signed CW-bit field at bits [u*CW +: CW] of COEF_VEC.
- R4: A sample presented while in_valid is low never enters the history and has no effect on later outputs.
- R5: A single nonzero sample of value 2^CF, with zeros before and after it, produces the outputs a_0, a_1, ..., a_H, ..., a_1, a_0 on the ORDER+1 accepted samples starting with it.
- R6: Results outside the signed SW-bit range are clipped to 2^(SW-1)-1 or -2^(SW-1).
- R7: With TRUNC_COLS = T > 0, the output is within one LSB of the R3 value. This holds when the total nonzero digit count D satisfies D*(2^T-1)/2 < 2^CF.
- R8: Any coefficient in the signed CW-bit range is applied exactly in the R3 mode, including the most negative value and zero.
- R9: out_sample holds its value through every cycle that follows a cycle with in_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_sample in this cycle |
| in_sample | input | SW | Signed input sample |
| out_valid | output | 1 | A new filtered sample is present |
| out_sample | output | SW | Signed filtered, rounded and clipped sample |

## Verification
- A wrong value in the history registers shows up on out_sample at the next accepted sample. It stays visible for up to ORDER+1 outputs, until the wrong value shifts out.
- A mis-recoded digit, or a wrong row in the merged matrix, shows up on the first output whose folded input for that coefficient is nonzero. An impulse exposes each coefficient on its own, one output at a time.
- A fault in the valid register appears one cycle after the input that should have set or cleared it.
- An idle sample that leaks into the history corrupts the very next accepted output.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    // Signed-digit set: a +1 or -1 digit at each bit position.
    typedef struct packed {
        logic [31:0] pos;
        logic [31:0] neg;
    } digit_set_t;

    function automatic int ones32(logic [31:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int digit_count(digit_set_t d);
        return ones32(d.pos) + ones32(d.neg);
    endfunction

    // Canonical signed digit form of a signed value of the given width.
    function automatic digit_set_t csd_digits(int value, int width);
        digit_set_t d;
        int         v;
        d = '0;
        v = value;
        for (int i = 0; i < 32; i++) begin
            if (i <= width) begin
                if ((v & 1) != 0) begin
                    if ((v & 3) == 1) begin
                        d.pos[i] = 1'b1;
                        v = v - 1;
                    end else begin
                        d.neg[i] = 1'b1;
                        v = v + 1;
                    end
                end
                v = v >>> 1;
            end
        end
        return d;
    endfunction

    // Radix-4 Booth form; a +/-2 digit at position 2j becomes +/-1 at 2j+1.
    function automatic digit_set_t booth_digits(int value, int width);
        digit_set_t d;
        d = '0;
        for (int j = 0; j < 16; j++) begin
            if (2 * j < width) begin
                int hi;
                int mid;
                int lo;
                int dg;
                hi  = (value >>> (2 * j + 1)) & 1;
                mid = (value >>> (2 * j)) & 1;
                lo  = (j == 0) ? 0 : ((value >>> (2 * j - 1)) & 1);
                dg  = mid + lo - 2 * hi;
                if (dg == 1)       d.pos[2 * j]     = 1'b1;
                else if (dg == -1) d.neg[2 * j]     = 1'b1;
                else if (dg == 2)  d.pos[2 * j + 1] = 1'b1;
                else if (dg == -2) d.neg[2 * j + 1] = 1'b1;
            end
        end
        return d;
    endfunction

    // Keep whichever recoding needs fewer matrix rows (ties keep CSD).
    function automatic digit_set_t recode(int value, int width);
        digit_set_t c;
        digit_set_t b;
        c = csd_digits(value, width);
        b = booth_digits(value, width);
        return (digit_count(b) < digit_count(c)) ? b : c;
    endfunction

    // Number of 3:2 levels needed to bring a row count down to two.
    function automatic int csa_levels(int rows);
        int n;
        int l;
        n = rows;
        l = 0;
        while (n > 2) begin
            n = 2 * (n / 3) + (n % 3);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/symfir_sample_line.sv
module symfir_sample_line #(
    parameter int SW    = 12,
    parameter int ORDER = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic [SW-1:0]           din,
    output logic [ORDER/2:0][SW:0]  pre
);

    localparam int HALF = ORDER / 2;
    localparam int PW   = SW + 1;

    typedef struct packed {
        logic [ORDER-1:0][SW-1:0] hist;   // hist[j] holds x(n-1-j)
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (shift_en) begin
            line_d.hist[0] = din;
            for (int j = 1; j < ORDER; j++) line_d.hist[j] = line_q.hist[j-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    function automatic logic [PW-1:0] widen(logic [SW-1:0] s);
        return {s[SW-1], s};
    endfunction

    // Fold mirrored taps: tap t is din for t = 0, hist[t-1] otherwise.
    for (genvar i = 0; i <= HALF; i++) begin : g_fold
        if (i == 0) begin : g_edge
            assign pre[i] = widen(din) + widen(line_q.hist[ORDER-1]);
        end else if (i < HALF) begin : g_pair
            assign pre[i] = widen(line_q.hist[i-1]) + widen(line_q.hist[ORDER-1-i]);
        end else begin : g_mid
            assign pre[i] = widen(line_q.hist[i-1]);
        end
    end

    // R4: idle cycles leave the history untouched
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(line_q));

    // R4: an accepted sample becomes the newest history entry
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> line_q.hist[0] == $past(din));

endmodule

// File: rtl/symfir_pp_matrix.sv
module symfir_pp_matrix #(
    parameter int SW         = 12,
    parameter int ORDER      = 8,
    parameter int CW         = 10,
    parameter int CF         = 9,
    parameter int TRUNC_COLS = 0,
    parameter int W          = 28,
    parameter logic [(ORDER/2+1)*CW-1:0] COEF_VEC = '0
) (
    input  logic [ORDER/2:0][SW:0]                  pre,
    output logic [(ORDER/2+1)*(CW+1):0][W-1:0]      rows
);

    localparam int HALF = ORDER / 2;
    localparam int PW   = SW + 1;
    localparam int NR   = (HALF + 1) * (CW + 1) + 1;

    function automatic int coef_at(int u);
        logic [CW-1:0] raw;
        raw = COEF_VEC[u*CW +: CW];
        return int'($signed(raw));
    endfunction

    function automatic int digit_total(int only_neg);
        int n;
        symfir_pkg::digit_set_t d;
        n = 0;
        for (int u = 0; u <= HALF; u++) begin
            d = symfir_pkg::recode(coef_at(u), CW);
            n += (only_neg != 0) ? symfir_pkg::ones32(d.neg) : symfir_pkg::digit_count(d);
        end
        return n;
    endfunction

    localparam int LIVE_ROWS = digit_total(0);
    localparam int NEG_ROWS  = digit_total(1);
    localparam int COMP      = (LIVE_ROWS * ((1 << TRUNC_COLS) - 1)) / 2;
    localparam int RND       = (CF > 0) ? (1 << (CF - 1)) : 0;
    localparam logic [W-1:0] KEEP      = ~((W'(1) << TRUNC_COLS) - W'(1));
    localparam logic [W-1:0] CONST_ROW = W'(NEG_ROWS + COMP + RND);

    for (genvar u = 0; u <= HALF; u++) begin : g_coef
        localparam symfir_pkg::digit_set_t DS = symfir_pkg::recode(coef_at(u), CW);
        logic [W-1:0] wide;
        assign wide = {{(W-PW){pre[u][PW-1]}}, pre[u]};
        for (genvar k = 0; k <= CW; k++) begin : g_dig
            if (DS.pos[k]) begin : g_plus
                assign rows[u*(CW+1)+k] = (wide << k) & KEEP;
            end else if (DS.neg[k]) begin : g_minus
                // -(v) = ~v + 1; the +1 is gathered into the constant row
                assign rows[u*(CW+1)+k] = ~(wide << k) & KEEP;
            end else begin : g_zero
                assign rows[u*(CW+1)+k] = '0;
            end
        end
    end

    // Constant row: negation ones, truncation compensation, rounding half.
    assign rows[NR-1] = CONST_ROW;

endmodule

// File: rtl/symfir_csa_tree.sv
module symfir_csa_tree #(
    parameter int W  = 28,
    parameter int NR = 56
) (
    input  logic [NR-1:0][W-1:0] rows,
    output logic [W-1:0]         sum_row,
    output logic [W-1:0]         carry_row
);

    localparam int LEVELS = symfir_pkg::csa_levels(NR);
    localparam int IW     = (NR > 1) ? $clog2(NR) : 1;

    always_comb begin
        logic [W-1:0] cur [NR];
        logic [W-1:0] nxt [NR];
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] d;
        int n;
        int m;
        for (int r = 0; r < NR; r++) cur[r] = rows[r];
        n = NR;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            for (int r = 0; r < NR; r++) nxt[r] = '0;
            for (int g = 0; g < NR / 3; g++) begin
                if (g < n / 3) begin
                    a = cur[3*g];
                    b = cur[3*g+1];
                    d = cur[3*g+2];
                    nxt[2*g]   = a ^ b ^ d;
                    nxt[2*g+1] = ((a & b) | (a & d) | (b & d)) << 1;
                end
            end
            m = 2 * (n / 3);
            for (int r = 0; r < 2; r++) begin
                if (r < n % 3) nxt[IW'(m + r)] = cur[IW'(3 * (n / 3) + r)];
            end
            n = m + n % 3;
            for (int r = 0; r < NR; r++) cur[r] = nxt[r];
        end
        sum_row   = cur[0];
        carry_row = cur[1];
    end

endmodule

// File: rtl/symfir_merged.sv
module symfir_merged #(
    parameter int SW         = 12,
    parameter int ORDER      = 8,
    parameter int CW         = 10,
    parameter int CF         = 9,
    parameter int TRUNC_COLS = 0,
    parameter logic [(ORDER/2+1)*CW-1:0] COEF_VEC =
        {10'(160), 10'(110), 10'(40), 10'(-5), 10'(-9)}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_sample,
    output logic          out_valid,
    output logic [SW-1:0] out_sample
);

    localparam int HALF = ORDER / 2;
    localparam int W    = SW + CW + $clog2(HALF + 1) + 3;
    localparam int NR   = (HALF + 1) * (CW + 1) + 1;
    localparam logic signed [W-1:0] MAXV = W'((1 << (SW - 1)) - 1);
    localparam logic signed [W-1:0] MINV = -W'(1 << (SW - 1));

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] y;
    } out_t;

    logic [HALF:0][SW:0]   pre;
    logic [NR-1:0][W-1:0]  rows;
    logic [W-1:0]          sum_row;
    logic [W-1:0]          carry_row;
    logic signed [W-1:0]   total;
    logic signed [W-1:0]   scaled;
    out_t                  out_d, out_q;

    symfir_sample_line #(.SW(SW), .ORDER(ORDER)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_sample),
        .pre      (pre)
    );

    symfir_pp_matrix #(
        .SW(SW), .ORDER(ORDER), .CW(CW), .CF(CF),
        .TRUNC_COLS(TRUNC_COLS), .W(W), .COEF_VEC(COEF_VEC)
    ) u_matrix (
        .pre  (pre),
        .rows (rows)
    );

    symfir_csa_tree #(.W(W), .NR(NR)) u_tree (
        .rows      (rows),
        .sum_row   (sum_row),
        .carry_row (carry_row)
    );

    always_comb begin
        total  = sum_row + carry_row;     // the single carry-propagate adder
        scaled = total >>> CF;
        out_d  = out_q;
        out_d.vld = in_valid;
        if (in_valid) begin
            if (scaled > MAXV)      out_d.y = MAXV[SW-1:0];
            else if (scaled < MINV) out_d.y = MINV[SW-1:0];
            else                    out_d.y = scaled[SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid  = out_q.vld;
    assign out_sample = out_q.y;

    // Reference total of all matrix rows, for the compression check
    logic [W-1:0] row_total;
    always_comb begin
        row_total = '0;
        for (int r = 0; r < NR; r++) row_total = row_total + rows[r];
    end

    // R3: carry-save reduction keeps the sum of the merged matrix
    a_r3_tree_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_row + carry_row) == row_total);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

    a_r6_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (scaled > MAXV)) |=> out_sample == MAXV[SW-1:0]);

    a_r6_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (scaled < MINV)) |=> out_sample == MINV[SW-1:0]);

endmodule

// File: tb/sim_symfir_merged.sv
`timescale 1ns/1ps
module sim_symfir_merged;

    localparam logic [49:0] CV0 = {10'(-512), 10'(130), 10'(44), 10'(0), 10'(-6)};
    localparam logic [49:0] CV1 = {10'(400), 10'(250), 10'(120), 10'(-60), 10'(30)};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [11:0] in_sample;
    logic        v0, v1;
    logic [11:0] y0, y1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int c0[5] = '{-6, 0, 44, 130, -512};
    int c1[5] = '{30, -60, 120, 250, 400};
    int hist[9];
    logic [31:0] lfsr = 32'h1234_5679;

    always #2.5 clk = ~clk;

    symfir_merged #(.SW(12), .ORDER(8), .CW(10), .CF(9), .TRUNC_COLS(0), .COEF_VEC(CV0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v0), .out_sample(y0));

    symfir_merged #(.SW(12), .ORDER(8), .CW(10), .CF(9), .TRUNC_COLS(5), .COEF_VEC(CV1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v1), .out_sample(y1));

    function automatic int model(bit second);
        longint s;
        int cf;
        s = 0;
        for (int i = 0; i < 4; i++) begin
            cf = second ? c1[i] : c0[i];
            s += longint'(cf) * longint'(hist[i] + hist[8-i]);
        end
        cf = second ? c1[4] : c0[4];
        s += longint'(cf) * longint'(hist[4]);
        s = (s + 256) >>> 9;
        if (s > 2047)  s = 2047;
        if (s < -2048) s = -2048;
        return int'(s);
    endfunction

    task automatic check_eq(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_near(string req, string what, int got, int exp);
        checks++;
        if (got > exp + 1 || got < exp - 1) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d +/-1", req, what, got, exp);
        end
    endtask

    task automatic step(bit v, int x);
        in_valid  = v;
        in_sample = 12'(x);
        if (v) begin
            for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = x;
        end
        @(negedge clk);
    endtask

    task automatic check_outputs(string req0, string req1);
        check_eq(req0, "u0 out", int'($signed(y0)), model(1'b0));
        check_near(req1, "u1 out", int'($signed(y1)), model(1'b1));
        check_eq("R2", "valid", int'(v0) + int'(v1), 2);
    endtask

    function automatic int next_sample();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return int'($signed(lfsr[11:0]));
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_sample = '0;
        for (int i = 0; i < 9; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        check_eq("R1", "u0 out in reset", int'(y0), 0);
        check_eq("R1", "u1 out in reset", int'(y1), 0);
        check_eq("R1", "valid in reset", int'(v0) + int'(v1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "valid after reset", int'(v0) + int'(v1), 0);
    endtask

    task automatic t_first();
        step(1'b1, 1000);
        check_outputs("R1", "R1");
        step(1'b1, -777);
        check_outputs("R3", "R7");
    endtask

    task automatic t_impulse();
        for (int i = 0; i < 9; i++) step(1'b1, 0);
        for (int j = 0; j <= 8; j++) begin
            int k;
            k = (j <= 4) ? j : 8 - j;
            step(1'b1, (j == 0) ? 512 : 0);
            check_eq((k == 4 || k == 1) ? "R8" : "R5", "u0 impulse", int'($signed(y0)), c0[k]);
            check_near("R7", "u1 impulse", int'($signed(y1)), c1[k]);
        end
    endtask

    task automatic t_stream();
        for (int i = 0; i < 300; i++) begin
            step(1'b1, next_sample());
            check_outputs("R3", "R7");
        end
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 40; i++) begin
            int p0;
            int p1;
            step(1'b1, next_sample());
            check_outputs("R4", "R4");
            p0 = int'(y0);
            p1 = int'(y1);
            step(1'b0, next_sample());
            check_eq("R2", "valid idle", int'(v0) + int'(v1), 0);
            check_eq("R9", "u0 hold", int'(y0), p0);
            check_eq("R9", "u1 hold", int'(y1), p1);
        end
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 2047);
            check_outputs("R6", "R6");
        end
        check_eq("R6", "u1 clip high", int'($signed(y1)), 2047);
        for (int i = 0; i < 12; i++) begin
            step(1'b1, -2048);
            check_outputs("R6", "R6");
        end
        check_eq("R6", "u1 clip low", int'($signed(y1)), -2048);
    endtask

    task automatic t_extreme();
        for (int i = 0; i < 40; i++) begin
            step(1'b1, ((i % 3) == 0) ? 2047 : -2048);
            check_outputs("R3", "R7");
        end
    endtask

    task automatic t_mid_reset();
        step(1'b1, 1500);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R1", "u0 out mid reset", int'(y0), 0);
        check_eq("R1", "valid mid reset", int'(v0) + int'(v1), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 9; i++) hist[i] = 0;
        @(negedge clk);
        step(1'b1, 700);
        check_outputs("R1", "R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog got no finish expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_sample = '0;
        @(negedge clk);
        t_reset();
        t_first();
        t_impulse();
        t_stream();
        t_gaps();
        t_saturate();
        t_extreme();
        t_mid_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule